// File: doc/BRIEF.md
# ATM Diagnostic Cell Source

This block builds ATM test cells for line-side diagnostics and pushes them, one byte per clock, into a transmit cell FIFO. Software programs four header bytes and a control register through a small register write port. The block then assembles each 53-byte cell. The four programmed header bytes come first, then a header check byte, then 48 payload bytes. The payload bytes come from a free-running pseudo-random byte generator.

Two traffic modes exist. A one-shot trigger produces exactly one cell per rising edge of the start bit. A continuous enable produces cells back to back until software clears it. The FIFO's full flag stalls the block in place, so nothing is dropped or repeated. A start-of-cell marker travels with the first header byte of every cell.

Top module: `atm_tcell_gen`

## Requirements
- R1: The first four bytes of each cell are the header bytes written at register addresses 0, 1, 2 and 3, sent in that address order.
- R2: Byte 4 of each cell is the CRC-8 (polynomial x^8+x^2+x+1, initial value 0, most significant bit first) of the four header bytes, XORed with 0x55.
- R3: Bytes 5 to 52 come from a 15-bit LFSR (x^15+x^14+1) seeded to all ones at reset. For each payload byte it shifts eight times: new bit = s[14]^s[13], s = {s[13:0], new bit}. The eight new bits form the byte, the first new bit in bit 7. The sequence carries on across cells.
- R4: A cell is exactly 53 FIFO writes. fifo_soc is high on the first header byte and on no other byte.
- R5: Control register address 4, bit 1, is the start trigger. A 0-to-1 write of this bit while idle produces exactly one cell. busy rises on the clock after that write and falls after the cell's last byte. A rising edge of this bit while busy is ignored.
- R6: Control bit 0 set to 1 selects continuous mode. In this mode cells follow each other with no idle cycle when the FIFO is not full.
- R7: Clearing control bit 0 during a cell lets that cell finish. Generation then stops, so only whole cells are written.
- R8: While fifo_full is high, fifo_wr stays low and fifo_data/fifo_soc hold. When full drops, output resumes from the same byte.
- R9: After reset, busy and fifo_wr are low.
- R10: Header registers are copied when a cell starts. A header write during a cell affects only later cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-3 header, 4 control) |
| reg_wdata | input | 8 | Register write data |
| fifo_full | input | 1 | FIFO full, stalls output |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | 8 | Cell byte |
| fifo_soc | output | 1 | Start-of-cell marker |
| busy | output | 1 | A cell is in progress |

## Verification
The bench uses the default values: 48 payload bytes, the 0x55 coset and the all-ones seed. Every cell therefore matches the real 53-byte format, and the CRC and LFSR models apply unchanged. With the payload this long, a pseudo-random full pattern lands stalls on header, check and payload bytes alike. A continuous run of four cells is long enough to change the header mid-cell and to clear the mode mid-cell in the same scenario.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int HDR_BYTES = 4;
  typedef logic [HDR_BYTES-1:0][7:0] hdr_t;

  // Header check: CRC-8 (x^8+x^2+x+1), MSB first, byte 0 first, then coset XOR
  function automatic logic [7:0] hec_of(hdr_t h, logic [7:0] coset);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int b = 0; b < HDR_BYTES; b++) begin
      for (int k = 7; k >= 0; k--) begin
        fb = c[7] ^ h[b][k];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c ^ coset;
  endfunction

  // Advance the x^15+x^14+1 register by eight steps
  function automatic logic [14:0] prbs_adv8(logic [14:0] s);
    logic [14:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[13:0], t[14] ^ t[13]};
    return t;
  endfunction
endpackage

// File: rtl/tcg_prbs.sv
module tcg_prbs #(
  parameter logic [14:0] SEED = 15'h7FFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [7:0] byte_o
);
  logic [14:0] st, nxt;

  assign nxt    = tcg_pkg::prbs_adv8(st);
  assign byte_o = nxt[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= SEED;
    else if (adv) st <= nxt;
  end

  // R3: the generator never locks up in the all-zero state
  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n) st != '0);
  // R8: state only moves when a payload byte is taken
  a_r8_prbs_hold: assert property (@(posedge clk) disable iff (!rst_n) !adv |=> $stable(st));
endmodule

// File: rtl/tcg_regs.sv
module tcg_regs (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output tcg_pkg::hdr_t     hdr,
  output logic              cont_en,
  output logic              start_pulse
);
  localparam logic [2:0] CTRL_ADDR = 3'd4;
  logic start_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr         <= '0;
      cont_en     <= 1'b0;
      start_bit   <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (we) begin
        if (addr < CTRL_ADDR) hdr[addr[1:0]] <= wdata;
        else if (addr == CTRL_ADDR) begin
          cont_en     <= wdata[0];
          start_bit   <= wdata[1];
          start_pulse <= wdata[1] & ~start_bit;
        end
      end
    end
  end

  // R5: a trigger pulse lasts exactly one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> !start_pulse);
endmodule

// File: rtl/tcg_seq.sv
module tcg_seq #(
  parameter int CELL_BYTES = 53,
  localparam int CW = $clog2(CELL_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cont_en,
  input  logic          start_pulse,
  input  logic          fifo_full,
  output logic          running,
  output logic [CW-1:0] cnt,
  output logic          take,
  output logic          cell_done,
  output logic          launch
);
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);
  logic idle_launch;

  assign take        = running && !fifo_full;
  assign cell_done   = take && (cnt == LAST);
  assign idle_launch = !running && (cont_en || start_pulse);
  assign launch      = idle_launch || (cell_done && cont_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (idle_launch) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (take) begin
      cnt <= cell_done ? '0 : cnt + 1'b1;
      if (cell_done) running <= cont_en;
    end
  end

  // R4: the byte index stays inside one cell
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
  // R5: an idle trigger starts a cell on the next clock
  a_r5_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start_pulse) |=> (running && cnt == '0));
  // R7: with continuous mode off, the last byte ends activity
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_done && !cont_en) |=> !running);
  // R6: with continuous mode on, the next cell starts at once
  a_r6_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_done && cont_en) |=> (running && cnt == '0));
endmodule

// File: rtl/atm_tcell_gen.sv
module atm_tcell_gen #(
  parameter int          PAY_BYTES  = 48,
  parameter logic [7:0]  HEC_COSET  = 8'h55,
  parameter logic [14:0] PRBS_SEED  = 15'h7FFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       fifo_full,
  output logic       fifo_wr,
  output logic [7:0] fifo_data,
  output logic       fifo_soc,
  output logic       busy
);
  localparam int CELL_BYTES = tcg_pkg::HDR_BYTES + 1 + PAY_BYTES;
  localparam int CW = $clog2(CELL_BYTES);
  localparam logic [CW-1:0] HEC_IDX = CW'(tcg_pkg::HDR_BYTES);

  tcg_pkg::hdr_t hdr_reg, hdr_shadow;
  logic          cont_en, start_pulse;
  logic          running, take, cell_done, launch;
  logic [CW-1:0] cnt;
  logic [7:0]    prbs_byte, hec_byte;
  logic          prbs_adv;

  tcg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hdr(hdr_reg), .cont_en(cont_en), .start_pulse(start_pulse)
  );

  tcg_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .start_pulse(start_pulse),
    .fifo_full(fifo_full), .running(running), .cnt(cnt), .take(take),
    .cell_done(cell_done), .launch(launch)
  );

  assign prbs_adv = take && (cnt > HEC_IDX);

  tcg_prbs #(.SEED(PRBS_SEED)) u_prbs (
    .clk(clk), .rst_n(rst_n), .adv(prbs_adv), .byte_o(prbs_byte)
  );

  // Header snapshot at every cell start keeps header and check byte coherent
  always_ff @(posedge clk) begin
    if (!rst_n)      hdr_shadow <= '0;
    else if (launch) hdr_shadow <= hdr_reg;
  end

  assign hec_byte = tcg_pkg::hec_of(hdr_shadow, HEC_COSET);

  always_comb begin
    if (cnt < HEC_IDX)       fifo_data = hdr_shadow[cnt[1:0]];
    else if (cnt == HEC_IDX) fifo_data = hec_byte;
    else                     fifo_data = prbs_byte;
  end

  assign fifo_wr  = take;
  assign fifo_soc = running && (cnt == '0);
  assign busy     = running;

  // R8: nothing is written into a full FIFO
  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);
  // R8: a stalled byte is presented unchanged on the next clock
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (running && fifo_full) |=> ($stable(fifo_data) && $stable(fifo_soc)));
  // R10: the snapshot only changes when a new cell starts
  a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(hdr_shadow));
  // R4: the marker appears only while a cell is in progress
  a_r4_soc_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_soc |-> busy);
endmodule

// File: tb/sim_atm_tcell_gen.sv
module sim_atm_tcell_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       fifo_full = 1'b0;
  logic       fifo_wr, fifo_soc, busy;
  logic [7:0] fifo_data;

  always #2 clk = ~clk;

  atm_tcell_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .fifo_soc(fifo_soc), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, chk_ptr = 0, mon_n = 0, stall_seen = 0;
  logic [7:0] mon_d [4096];
  logic       mon_s [4096];
  int         mon_c [4096];
  logic       stall_en = 1'b0;
  logic [4:0] st_l = 5'h1B;
  logic [14:0] m_prbs = 15'h7FFF;
  logic        finished = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    st_l <= {st_l[3:0], st_l[4] ^ st_l[2]};
    fifo_full <= stall_en & st_l[0];
  end

  always @(negedge clk) begin
    if (rst_n && fifo_full && busy) stall_seen++;
    if (rst_n && fifo_wr && mon_n < 4096) begin
      mon_d[mon_n] = fifo_data;
      mon_s[mon_n] = fifo_soc;
      mon_c[mon_n] = cyc;
      mon_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (r[i]) r[i-:9] = r[i-:9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  function automatic logic [7:0] m_byte();
    logic [7:0] b;
    logic       fb;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      fb = m_prbs[14] ^ m_prbs[13];
      b = {b[6:0], fb};
      m_prbs = {m_prbs[13:0], fb};
    end
    return b;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_hdr(input logic [31:0] h);
    for (int i = 0; i < 4; i++) wr_reg(3'(i), h[31-8*i -: 8]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // h holds byte 0 in its top eight bits
  task automatic check_next_cell(input logic [31:0] h, input string hreq);
    int eh = 0, ep = 0, es = 0, fa = 0, fe = 0;
    logic [7:0] ex;
    if (mon_n < chk_ptr + 53) begin
      check(0, "R4", "cell bytes present", mon_n - chk_ptr, 53);
      return;
    end
    for (int i = 0; i < 53; i++) begin
      if (i < 4) ex = h[31-8*i -: 8];
      else if (i == 4) ex = m_hec(h);
      else ex = m_byte();
      if (mon_s[chk_ptr+i] != (i == 0)) es++;
      if (mon_d[chk_ptr+i] != ex) begin
        if (i < 4) eh++; else if (i > 4) ep++;
        if (fa == 0 && fe == 0) begin fa = mon_d[chk_ptr+i]; fe = ex; end
      end
      if (i == 4) check(mon_d[chk_ptr+4] == ex, "R2", "check byte", mon_d[chk_ptr+4], ex);
    end
    check(eh == 0, hreq, "header bytes", fa, fe);
    check(ep == 0, "R3", "payload bytes", fa, fe);
    check(es == 0, "R4", "soc placement errors", es, 0);
    chk_ptr += 53;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after reset", busy, 0);
    check(fifo_wr == 1'b0, "R9", "fifo_wr after reset", fifo_wr, 0);
    check(mon_n == 0, "R9", "bytes before start", mon_n, 0);
  endtask

  task automatic t_oneshot();
    set_hdr(32'h11223344);
    wr_reg(3'd4, 8'h02);
    check(busy == 1'b0, "R5", "busy before launch edge", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R5", "busy after trigger", busy, 1);
    check(fifo_soc == 1'b1, "R4", "soc on first byte", fifo_soc, 1);
    wr_reg(3'd4, 8'h00);
    wait_idle();
    check(mon_n == chk_ptr + 53, "R5", "one-shot byte count", mon_n - chk_ptr, 53);
    check_next_cell(32'h11223344, "R1");
  endtask

  task automatic t_ignore_busy();
    set_hdr(32'hA5C3_0F81);
    wr_reg(3'd4, 8'h02);
    repeat (5) @(negedge clk);
    wr_reg(3'd4, 8'h00);
    wr_reg(3'd4, 8'h02);
    wr_reg(3'd4, 8'h00);
    wait_idle();
    check(mon_n == chk_ptr + 53, "R5", "trigger while busy ignored", mon_n - chk_ptr, 53);
    check_next_cell(32'hA5C30F81, "R1");
  endtask

  task automatic t_backpressure();
    int s0 = stall_seen;
    set_hdr(32'h00000000);
    stall_en = 1'b1;
    wr_reg(3'd4, 8'h02);
    wr_reg(3'd4, 8'h00);
    wait_idle();
    stall_en = 1'b0;
    check(stall_seen > s0, "R8", "stall cycles seen", stall_seen - s0, 1);
    check(mon_n == chk_ptr + 53, "R8", "bytes under stall", mon_n - chk_ptr, 53);
    check_next_cell(32'h00000000, "R8");
  endtask

  task automatic t_continuous();
    int i0 = mon_n;
    set_hdr(32'hDEADBEEF);
    wr_reg(3'd4, 8'h01);
    while (mon_n < i0 + 73) @(negedge clk);
    set_hdr(32'h0102FE7F);
    while (mon_n < i0 + 3*53 + 10) @(negedge clk);
    check(mon_c[i0+158] - mon_c[i0] == 158, "R6", "cycles over three cells",
          mon_c[i0+158] - mon_c[i0], 158);
    wr_reg(3'd4, 8'h00);
    check(busy == 1'b1, "R7", "cell still running after clear", busy, 1);
    wait_idle();
    check(mon_n - i0 == 4*53, "R7", "whole cells only", mon_n - i0, 4*53);
    check_next_cell(32'hDEADBEEF, "R6");
    check_next_cell(32'hDEADBEEF, "R10");
    check_next_cell(32'h0102FE7F, "R10");
    check_next_cell(32'h0102FE7F, "R1");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_ignore_busy();
    t_backpressure();
    t_continuous();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule